// File: doc/BRIEF.md
# Two-Port Mailbox and Interrupt Controller

This block sits between two upstream bus masters that share one downstream bus. It gives the two masters a one-word mailbox in each direction and drives an active-low interrupt line to each of them. A master writes a word into its outgoing slot. The other master is then told that mail is waiting, and the writer is told that its mail has not yet been collected. The receiver's read of the slot clears both indications.

Each interrupt line merges five sources. Two come from the mailboxes: incoming mail waiting, and outgoing mail not yet read. Two are sticky events delivered as one-cycle pulses by an arbiter outside this block: bus granted and bus lost. The fifth is the level of a downstream interrupt input, which is synchronised and forwarded to both masters. Every source can be enabled or masked separately for each master. The combined line is registered, so it cannot glitch.

Status vectors are five bits wide, with fixed positions: bit 0 incoming mail waiting, bit 1 outgoing mail unread, bit 2 bus granted, bit 3 bus lost, bit 4 downstream interrupt level. The same positions are used by the enable and clear vectors. Per-master vectors are packed with master 0 in the low slice.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, both status vectors are zero, both mailbox data words are zero and both `irq_n_o` bits are 1.
- R2: A write strobe from master j stores the write data into the slot addressed to the other master. On the next cycle, that master's `rdata_o` shows the word and its status bit 0 is 1, and master j's status bit 1 is 1.
- R3: A read strobe from master i, while master i's status bit 0 is set and no write to that slot occurs in the same cycle, clears on the next cycle master i's bit 0 and the writer's bit 1.
- R4: A write into a slot that already holds unread mail replaces the data word; both flags stay at 1.
- R5: When a write and a read of the same slot happen in the same cycle, the write wins: the new word is stored and both flags are 1 on the next cycle.
- R6: A one-cycle `grant_i[i]` or `lost_i[i]` pulse sets master i's status bit 2 or bit 3. The bit stays set until master i pulses bit 2 or bit 3 of its `clr_i` slice. Clear bits 0, 1 and 4 have no effect. A set and a clear in the same cycle leave the bit at 1.
- R7: Status bit 4 of both masters follows `dn_irq_i` delayed by `DN_SYNC` clock cycles and is not latched: it drops again when the input drops.
- R8: `irq_n_o[i]` is 0 exactly one cycle after a cycle in which (status of master i AND `en_i` of master i) is non-zero, and 1 otherwise. A masked source therefore never pulls the line low.
- R9: A read strobe on an empty slot changes neither flag nor the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata_i | input | 2*DATA_W | Mailbox write data, master 0 in low slice |
| wstb_i | input | 2 | Mailbox write strobe per master |
| rstb_i | input | 2 | Mailbox read strobe per master (reads the slot addressed to it) |
| rdata_o | output | 2*DATA_W | Word held in the slot addressed to each master |
| status_o | output | 10 | Five status bits per master |
| clr_i | input | 10 | Write-one-to-clear pulses per master (bits 2 and 3 act) |
| en_i | input | 10 | Per-master source enables (1 = source may interrupt) |
| grant_i | input | 2 | Bus-granted event pulse per master |
| lost_i | input | 2 | Bus-lost event pulse per master |
| dn_irq_i | input | 1 | Downstream interrupt level, active high |
| irq_n_o | output | 2 | Active-low registered interrupt per master |

## Verification
The bench builds the block with `DATA_W` = 12 and `DN_SYNC` = 2. The wider, non-byte data word shows that slicing per master is correct above bit 7. Two synchronizer stages make the downstream delay measurable: the bench checks that bit 4 stays low for one cycle and rises on the second. A behavioural model then runs against the design in lockstep through a long random stretch. In that stretch, writes and reads collide, events coincide with clears, and the enable masks change while sources are active.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
   localparam int SRC_N = 5;
   typedef enum int unsigned {
      SRC_MAIL_IN    = 0,
      SRC_OUT_UNREAD = 1,
      SRC_GRANT      = 2,
      SRC_LOST       = 3,
      SRC_DOWN       = 4
   } src_e;
   typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o
);
   logic [DATA_W-1:0] word_q;
   logic              full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         full_q <= 1'b0;
      end else if (wr_stb) begin
         word_q <= wr_data;
         full_q <= 1'b1;
      end else if (rd_stb) begin
         full_q <= 1'b0;
      end
   end

   assign data_o = word_q;
   assign full_o = full_q;

   p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (full_o && data_o == $past(wr_data)));
   p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !wr_stb) |=> !full_o);
   p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb) |=> $stable(data_o));
endmodule

// File: rtl/evt_sticky.sv
module evt_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/irq_merge.sv
module irq_merge import mbx_irq_pkg::*; (
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t stat_i,
   input  src_vec_t en_i,
   output logic     irq_n_o
);
   logic any_live;
   assign any_live = |(stat_i & en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_o <= 1'b1;
      else        irq_n_o <= ~any_live;
   end

   p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      any_live |=> !irq_n_o);
   p_irq_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_i == '0) |=> irq_n_o);
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl import mbx_irq_pkg::*; #(
   parameter int DATA_W  = 8,
   parameter int DN_SYNC = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*DATA_W-1:0]   wdata_i,
   input  logic [1:0]            wstb_i,
   input  logic [1:0]            rstb_i,
   output logic [2*DATA_W-1:0]   rdata_o,
   output logic [2*SRC_N-1:0]    status_o,
   input  logic [2*SRC_N-1:0]    clr_i,
   input  logic [2*SRC_N-1:0]    en_i,
   input  logic [1:0]            grant_i,
   input  logic [1:0]            lost_i,
   input  logic                  dn_irq_i,
   output logic [1:0]            irq_n_o
);
   localparam int MASTERS = 2;

   if (DATA_W < 1) begin : g_bad_width
      $error("mbx_irq_ctrl: DATA_W must be at least 1");
   end
   if (DN_SYNC < 0 || DN_SYNC > 4) begin : g_bad_sync
      $error("mbx_irq_ctrl: DN_SYNC must lie in 0..4");
   end

   // Downstream level: plain wire or a short synchronizer chain
   logic dn_lvl;
   if (DN_SYNC == 0) begin : g_dn_direct
      assign dn_lvl = dn_irq_i;
   end else begin : g_dn_sync
      logic [DN_SYNC-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else if (DN_SYNC == 1) chain_q <= dn_irq_i;
         else chain_q <= {chain_q[DN_SYNC-2:0], dn_irq_i};
      end
      assign dn_lvl = chain_q[DN_SYNC-1];
   end

   // Slot j carries mail written by master j toward master 1-j
   logic [DATA_W-1:0] slot_data [MASTERS];
   logic [MASTERS-1:0] slot_full;

   for (genvar j = 0; j < MASTERS; j++) begin : g_slot
      mbx_slot #(.DATA_W(DATA_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_stb  (wstb_i[j]),
         .wr_data (wdata_i[j*DATA_W +: DATA_W]),
         .rd_stb  (rstb_i[1-j]),
         .data_o  (slot_data[j]),
         .full_o  (slot_full[j])
      );
   end

   for (genvar i = 0; i < MASTERS; i++) begin : g_master
      logic     grant_q, lost_q;
      src_vec_t stat;

      evt_sticky u_grant (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (grant_i[i]),
         .clr_i (clr_i[i*SRC_N + SRC_GRANT]),
         .q_o   (grant_q)
      );
      evt_sticky u_lost (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (lost_i[i]),
         .clr_i (clr_i[i*SRC_N + SRC_LOST]),
         .q_o   (lost_q)
      );

      always_comb begin
         stat                 = '0;
         stat[SRC_MAIL_IN]    = slot_full[1-i];
         stat[SRC_OUT_UNREAD] = slot_full[i];
         stat[SRC_GRANT]      = grant_q;
         stat[SRC_LOST]       = lost_q;
         stat[SRC_DOWN]       = dn_lvl;
      end

      irq_merge u_irq (
         .clk     (clk),
         .rst_n   (rst_n),
         .stat_i  (stat),
         .en_i    (en_i[i*SRC_N +: SRC_N]),
         .irq_n_o (irq_n_o[i])
      );

      assign status_o[i*SRC_N +: SRC_N]  = stat;
      assign rdata_o[i*DATA_W +: DATA_W] = slot_data[1-i];
   end

   // Mail flags toward receiver and toward sender come from one slot flag
   p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[SRC_MAIL_IN] == status_o[SRC_N + SRC_OUT_UNREAD]);
   p_down_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[SRC_DOWN] == status_o[SRC_N + SRC_DOWN]);
   p_overwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wstb_i[0] && status_o[SRC_N + SRC_MAIL_IN]) |=> status_o[SRC_N + SRC_MAIL_IN]);
endmodule

// File: tb/sim_mbx_irq_ctrl.sv
module sim_mbx_irq_ctrl;
   localparam int DW = 12;
   localparam int NS = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2*DW-1:0] wdata = '0;
   logic [1:0]      wstb = '0, rstb = '0, grant = '0, lost = '0;
   logic [2*NS-1:0] clr = '0, en = '0;
   logic            dn = 1'b0;
   logic [2*DW-1:0] rdata;
   logic [2*NS-1:0] status;
   logic [1:0]      irq_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mbx_irq_ctrl #(.DATA_W(DW), .DN_SYNC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wdata_i(wdata), .wstb_i(wstb), .rstb_i(rstb),
      .rdata_o(rdata), .status_o(status), .clr_i(clr), .en_i(en),
      .grant_i(grant), .lost_i(lost), .dn_irq_i(dn), .irq_n_o(irq_n));

   // Behavioural reference
   logic [DW-1:0] m_box [2];
   bit  m_full [2], m_gr [2], m_lo [2];
   bit  m_d1, m_d2;
   bit  [1:0] m_irqn = 2'b11;

   function automatic logic [NS-1:0] m_stat(int i);
      return {m_d2, m_lo[i], m_gr[i], m_full[i], m_full[1-i]};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < 2; j++) begin
            m_box[j] = '0; m_full[j] = 0; m_gr[j] = 0; m_lo[j] = 0;
         end
         m_d1 = 0; m_d2 = 0; m_irqn = 2'b11;
      end else begin
         logic [NS-1:0] s0, s1;
         s0 = m_stat(0);
         s1 = m_stat(1);
         m_irqn[0] = ((s0 & en[NS-1:0]) == 0);
         m_irqn[1] = ((s1 & en[2*NS-1:NS]) == 0);
         for (int j = 0; j < 2; j++) begin
            if (wstb[j]) begin
               m_box[j] = wdata[j*DW +: DW];
               m_full[j] = 1;
            end else if (rstb[1-j]) m_full[j] = 0;
            if (grant[j]) m_gr[j] = 1; else if (clr[j*NS+2]) m_gr[j] = 0;
            if (lost[j])  m_lo[j] = 1; else if (clr[j*NS+3]) m_lo[j] = 0;
         end
         m_d2 = m_d1;
         m_d1 = dn;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Lockstep comparison each cycle
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         check("R2 R3 R4 R5 R9 model status0", 32'(status[NS-1:0]), 32'(m_stat(0)));
         check("R2 R6 R7 model status1", 32'(status[2*NS-1:NS]), 32'(m_stat(1)));
         check("R2 R4 model rdata0", 32'(rdata[DW-1:0]), 32'(m_box[1]));
         check("R2 R4 model rdata1", 32'(rdata[2*DW-1:DW]), 32'(m_box[0]));
         check("R8 model irq_n", 32'(irq_n), 32'(m_irqn));
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic idle();
      wstb = '0; rstb = '0; grant = '0; lost = '0; clr = '0;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      check("R1 reset status", 32'(status), 0);
      check("R1 reset irq", 32'(irq_n), 32'h3);
      check("R1 reset data", 32'(rdata), 0);
      rst_n = 1'b1;
      step(2);
      check("R1 after release status", 32'(status), 0);
      check("R1 after release irq", 32'(irq_n), 32'h3);

      en = {5'b00001, 5'b00000};           // master1 enables mail-in only
      wdata[DW-1:0] = 12'hABC; wstb[0] = 1;
      step(1); idle();
      check("R2 rdata1", 32'(rdata[2*DW-1:DW]), 32'hABC);
      check("R2 mail-in m1", 32'(status[NS+0]), 1);
      check("R2 unread m0", 32'(status[1]), 1);
      step(1);
      check("R8 irq1 low", 32'(irq_n[1]), 0);
      check("R8 masked m0 irq high", 32'(irq_n[0]), 1);

      wdata[DW-1:0] = 12'h923; wstb[0] = 1;
      step(1); idle();
      check("R4 overwrite data", 32'(rdata[2*DW-1:DW]), 32'h923);
      check("R4 flags stay", 32'({status[NS+0], status[1]}), 32'h3);

      rstb[1] = 1; step(1); idle();
      check("R3 flags cleared", 32'({status[NS+0], status[1]}), 0);
      step(1);
      check("R8 irq1 released", 32'(irq_n[1]), 1);

      rstb[1] = 1; step(1); idle();
      check("R9 empty read flags", 32'({status[NS+0], status[1]}), 0);
      check("R9 empty read data", 32'(rdata[2*DW-1:DW]), 32'h923);

      wdata[DW-1:0] = 12'h5A5; wstb[0] = 1; rstb[1] = 1;
      step(1); idle();
      check("R5 collide data", 32'(rdata[2*DW-1:DW]), 32'h5A5);
      check("R5 collide flag", 32'(status[NS+0]), 1);
      rstb[1] = 1; step(1); idle();

      grant[0] = 1; step(1); idle();
      check("R6 grant set", 32'(status[2]), 1);
      clr[NS-1:0] = 5'b10011; step(1); idle();
      check("R6 other clears ignored", 32'(status[2]), 1);
      clr[2] = 1; step(1); idle();
      check("R6 grant cleared", 32'(status[2]), 0);
      lost[1] = 1; clr[NS+3] = 1; step(1); idle();
      check("R6 set beats clear", 32'(status[NS+3]), 1);
      clr[NS+3] = 1; step(1); idle();
      check("R6 lost cleared", 32'(status[NS+3]), 0);

      en = {5'b10000, 5'b00000};
      dn = 1; step(1);
      check("R7 not yet", 32'(status[4]), 0);
      step(1);
      check("R7 after two", 32'({status[NS+4], status[4]}), 32'h3);
      step(1);
      check("R8 down irq1", 32'(irq_n), 32'h1);
      dn = 0; step(2);
      check("R7 not latched", 32'(status[4]), 0);

      for (int k = 0; k < 4000; k++) begin
         wdata = {12'($urandom), 12'($urandom)};
         wstb  = 2'($urandom) & 2'($urandom);
         rstb  = 2'($urandom);
         grant = 2'(($urandom % 11) == 0 ? $urandom : 0);
         lost  = 2'(($urandom % 13) == 0 ? $urandom : 0);
         clr   = 10'($urandom) & 10'($urandom);
         dn    = (($urandom % 7) == 0) ? ~dn : dn;
         if ((k % 50) == 0) en = 10'($urandom);
         step(1);
      end
      idle();
      step(3);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule